// File: doc/BRIEF.md
# CAN Transmit Message Queue Controller

This block keeps the bookkeeping for a circular transmit queue of fixed-size message objects that sit in a message RAM. The RAM and the objects' contents live outside the block. Software writes a message at the byte address shown on `user_addr`. It then pulses `ua_inc`, which moves that address on to the next object slot. When the ring has filled up, a further increment is dropped and a sticky error bit is set.

Software starts the send by pulsing `txreq_set`. While the request is up and at least one object is queued, `tx_valid` tells the transmit engine that an object is waiting at `ram_addr`. Each `tx_done` pulse retires that object and moves the hardware index on. After the last queued object leaves, the request drops by itself. The block also reports three status flags: ring empty, at least half of the slots free, and at least one slot free.

Top module: `can_txfifo_ctrl`

## Requirements
- R1: After reset the occupancy is 0 and both slot indices are 0. `user_addr` and `ram_addr` equal the base address. `flag_empty`, `flag_half` and `flag_notfull` read 1. `txreq`, `tx_valid` and `ovf_err` read 0.
- R2: A `ua_inc` pulse while a slot is free adds one object to the queue. It moves `user_addr` on by 72 bytes, and from slot 4 it wraps back to slot 0 (the base address).
- R3: A `ua_inc` pulse while all 5 slots are occupied leaves `user_addr` and the occupancy unchanged. It sets `ovf_err`, which then stays 1 until reset.
- R4: `flag_empty` is 1 exactly when no object is queued.
- R5: `flag_half` is 1 while at least half of the 5 slots are free (0 to 2 occupied). It is 0 with 3, 4 or 5 occupied.
- R6: `flag_notfull` is 0 only when all 5 slots are occupied.
- R7: `tx_valid` is 1 exactly when `txreq` is 1 and the queue is not empty. A `tx_done` pulse while `tx_valid` is 1 retires one object and moves `fifo_idx` on by one, wrapping from 4 to 0. `ram_addr` always equals base + 72 × `fifo_idx`.
- R8: When `tx_done` retires the only queued object, `txreq` clears and `flag_empty` sets on the next cycle. A `txreq_set` pulse sets `txreq` even when the queue is empty.
- R9: A `tx_done` pulse while `tx_valid` is 0 has no effect on `fifo_idx`, `ram_addr` or the flags.
- R10: While all 5 slots are occupied, `user_addr` equals `ram_addr`.
- R11: Loading and retiring in the same cycle on a partly filled queue advances both indices and leaves the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ua_inc | input | 1 | Software pulse: one message loaded, advance the user address |
| txreq_set | input | 1 | Software pulse: raise the transmit request |
| tx_done | input | 1 | Transmit engine pulse: the object at `ram_addr` has been sent |
| tx_valid | output | 1 | An object is waiting for the transmit engine |
| ram_addr | output | ADDR_W | Message RAM byte address of the object to transmit |
| txreq | output | 1 | Transmit request, cleared by hardware when the queue drains |
| user_addr | output | ADDR_W | Message RAM byte address where software loads next |
| fifo_idx | output | IDX_W | Slot index of the next object to transmit |
| flag_empty | output | 1 | No object queued |
| flag_half | output | 1 | At least half of the slots free |
| flag_notfull | output | 1 | At least one slot free |
| ovf_err | output | 1 | Sticky: an increment arrived while the queue was full |

## Verification
The hardest state to reach from the ports is a full ring in which the software and hardware indices sit on the same slot, and that slot is away from slot 0. Reaching it needs a partial drain before the refill. The stimulus first loads and drains three objects so that both indices rest on slot 3. It then loads five more, so the user index wraps past slot 4 and meets the hardware index there.

On that full ring, the stimulus tries a rejected increment. It then tries a rejected increment combined with a retire, and then a load and retire in the same cycle. The last object is drained to show the request clearing itself.

// File: rtl/can_txfifo_ctrl.sv
module can_txfifo_ctrl #(
  parameter int SLOTS      = 5,
  parameter int SLOT_BYTES = 72,
  parameter int ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h01D0,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ua_inc,
  input  logic              txreq_set,
  input  logic              tx_done,
  output logic              tx_valid,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              txreq,
  output logic [ADDR_W-1:0] user_addr,
  output logic [IDX_W-1:0]  fifo_idx,
  output logic              flag_empty,
  output logic              flag_half,
  output logic              flag_notfull,
  output logic              ovf_err
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  logic [IDX_W-1:0] uidx;
  logic [CNT_W-1:0] count;
  logic             load, sent;

  assign flag_empty   = (count == '0);
  assign flag_notfull = (count != CNT_W'(SLOTS));
  assign flag_half    = (2 * (SLOTS - int'(count)) >= SLOTS);
  assign tx_valid     = txreq && !flag_empty;

  assign load = ua_inc && flag_notfull;
  assign sent = tx_done && tx_valid;

  assign user_addr = BASE_ADDR + ADDR_W'(SLOT_BYTES * int'(uidx));
  assign ram_addr  = BASE_ADDR + ADDR_W'(SLOT_BYTES * int'(fifo_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uidx     <= '0;
      fifo_idx <= '0;
      count    <= '0;
      txreq    <= 1'b0;
      ovf_err  <= 1'b0;
    end else begin
      if (load)
        uidx <= (uidx == LAST) ? '0 : uidx + 1'b1;
      if (sent)
        fifo_idx <= (fifo_idx == LAST) ? '0 : fifo_idx + 1'b1;
      case ({load, sent})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (ua_inc && !flag_notfull)
        ovf_err <= 1'b1;
      if (txreq_set)
        txreq <= 1'b1;
      else if (sent && !load && count == CNT_W'(1))
        txreq <= 1'b0;
    end
  end

endmodule

// File: rtl/can_txfifo_ctrl_chk.sv
module can_txfifo_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ua_inc,
  input logic              txreq_set,
  input logic              tx_done,
  input logic              tx_valid,
  input logic              txreq,
  input logic              flag_empty,
  input logic              flag_half,
  input logic              flag_notfull,
  input logic              ovf_err,
  input logic [ADDR_W-1:0] user_addr,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [CNT_W-1:0]  count
);

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  assert_full_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ua_inc && !flag_notfull) |=> ($stable(user_addr) && ovf_err));

  assert_empty_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_empty |-> (flag_half && flag_notfull));

  assert_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (txreq && !flag_empty));

  assert_autoclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_done && count == CNT_W'(1) && !ua_inc && !txreq_set)
      |=> (!txreq && flag_empty));

  assert_idle_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && tx_done) |=> $stable(ram_addr));

  assert_full_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_notfull |-> (user_addr == ram_addr));

endmodule

bind can_txfifo_ctrl can_txfifo_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ua_inc(ua_inc), .txreq_set(txreq_set),
  .tx_done(tx_done), .tx_valid(tx_valid), .txreq(txreq),
  .flag_empty(flag_empty), .flag_half(flag_half), .flag_notfull(flag_notfull),
  .ovf_err(ovf_err), .user_addr(user_addr), .ram_addr(ram_addr), .count(count)
);

// File: tb/test_can_txfifo_ctrl.sv
`timescale 1ns/1ps
module test_can_txfifo_ctrl;

  localparam int SLOTS = 5;
  localparam int SLOT_BYTES = 72;
  localparam int ADDR_W = 16;
  localparam logic [ADDR_W-1:0] BASE = 16'h01D0;
  localparam int NV = 24;

  // {inc,set,done} {user slot} {fifo slot} {empty,half,notfull,txreq,valid,ovf}
  localparam logic [14:0] VEC [NV] = '{
    {3'b100, 3'd1, 3'd0, 6'b011000},  // R2 load
    {3'b100, 3'd2, 3'd0, 6'b011000},
    {3'b100, 3'd3, 3'd0, 6'b001000},  // R5 three loaded
    {3'b010, 3'd3, 3'd0, 6'b001110},  // R7 request
    {3'b001, 3'd3, 3'd1, 6'b011110},
    {3'b001, 3'd3, 3'd2, 6'b011110},
    {3'b001, 3'd3, 3'd3, 6'b111000},  // R8 auto clear
    {3'b001, 3'd3, 3'd3, 6'b111000},  // R9 idle done ignored
    {3'b100, 3'd4, 3'd3, 6'b011000},
    {3'b100, 3'd0, 3'd3, 6'b011000},  // R2 wrap
    {3'b100, 3'd1, 3'd3, 6'b001000},
    {3'b100, 3'd2, 3'd3, 6'b001000},
    {3'b100, 3'd3, 3'd3, 6'b000000},  // R6 R10 full
    {3'b100, 3'd3, 3'd3, 6'b000001},  // R3 overflow
    {3'b010, 3'd3, 3'd3, 6'b000111},
    {3'b101, 3'd3, 3'd4, 6'b001111},  // R3 rejected load with retire
    {3'b101, 3'd4, 3'd0, 6'b001111},  // R11 load and retire
    {3'b001, 3'd4, 3'd1, 6'b001111},
    {3'b001, 3'd4, 3'd2, 6'b011111},
    {3'b001, 3'd4, 3'd3, 6'b011111},
    {3'b001, 3'd4, 3'd4, 6'b111001},  // R8
    {3'b010, 3'd4, 3'd4, 6'b111101},  // R8 set on empty, R7 no valid
    {3'b100, 3'd0, 3'd4, 6'b011111},
    {3'b001, 3'd0, 3'd0, 6'b111001}   // R7 R8 wrap and clear
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ua_inc = 1'b0, txreq_set = 1'b0, tx_done = 1'b0;
  logic tx_valid, txreq, flag_empty, flag_half, flag_notfull, ovf_err;
  logic [ADDR_W-1:0] ram_addr, user_addr;
  logic [2:0] fifo_idx;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  can_txfifo_ctrl #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES), .ADDR_W(ADDR_W),
                    .BASE_ADDR(BASE)) i_can_txfifo_ctrl (
    .clk(clk), .rst_n(rst_n), .ua_inc(ua_inc), .txreq_set(txreq_set),
    .tx_done(tx_done), .tx_valid(tx_valid), .ram_addr(ram_addr), .txreq(txreq),
    .user_addr(user_addr), .fifo_idx(fifo_idx), .flag_empty(flag_empty),
    .flag_half(flag_half), .flag_notfull(flag_notfull), .ovf_err(ovf_err));

  function automatic logic [ADDR_W-1:0] slot_addr(input int s);
    return BASE + ADDR_W'(SLOT_BYTES * s);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input int us, input int fs, input logic [5:0] f);
    chk("R2", "user_addr", 32'(user_addr), 32'(slot_addr(us)));
    chk("R7", "fifo_idx", 32'(fifo_idx), 32'(fs));
    chk("R7", "ram_addr", 32'(ram_addr), 32'(slot_addr(fs)));
    chk("R4", "flag_empty", 32'(flag_empty), 32'(f[5]));
    chk("R5", "flag_half", 32'(flag_half), 32'(f[4]));
    chk("R6", "flag_notfull", 32'(flag_notfull), 32'(f[3]));
    chk("R8", "txreq", 32'(txreq), 32'(f[2]));
    chk("R7", "tx_valid", 32'(tx_valid), 32'(f[1]));
    chk("R3", "ovf_err", 32'(ovf_err), 32'(f[0]));
  endtask

  initial begin
    #(100000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state(0, 0, 6'b111000);  // R1 reset state

    for (int i = 0; i < NV; i++) begin
      {ua_inc, txreq_set, tx_done} = VEC[i][14:12];
      @(negedge clk);
      chk_state(int'(VEC[i][11:9]), int'(VEC[i][8:6]), VEC[i][5:0]);
      if (i == 12) chk("R10", "full user_addr vs ram_addr", 32'(user_addr), 32'(ram_addr));
    end
    {ua_inc, txreq_set, tx_done} = 3'b000;

    // R1: reset in mid-stream clears the sticky error and the indices
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state(0, 0, 6'b111000);

    // R9: retire pulses with nothing valid change nothing
    tx_done = 1'b1;
    repeat (2) @(negedge clk);
    tx_done = 1'b0;
    chk_state(0, 0, 6'b111000);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule